// File: doc/BRIEF.md
# Crosspoint Switch Serial Loader

This block programs a 16x16 analog crosspoint switch through its three-wire serial configuration port. It accepts a 256-bit switch map, one bit per crosspoint, and sends the whole map out on a data line under a generated serial clock. It then gives one low-going latch pulse that moves the shifted map into the switch's holding latch. Every update sends all 256 bits, even when only one crosspoint changes.

All three serial lines come from registers on one fast system clock. Each clock, data and latch edge therefore falls on a system-clock tick, at a spacing set by parameters. With the default 20 MHz system clock, a half serial period is 10 ticks, giving a 1 MHz serial clock. Data changes only when the serial clock falls, which leaves half a serial period of setup before each rising edge. The latch pulse comes a set number of ticks after the final falling edge.

A controller pulses `start` with the map on `map_in`. It watches `busy`, and takes the one-cycle `done` pulse as the sign that the switch has been updated.

The control state machine has five states:
- `XS_IDLE`: lines idle. `start` moves it to `XS_LEAD` and captures the map.
- `XS_LEAD`: serial clock low, data valid. After the half period it moves to `XS_TRAIL`.
- `XS_TRAIL`: serial clock high. After the half period it returns to `XS_LEAD` with the next bit. After the last bit it moves to `XS_GAP` instead.
- `XS_GAP`: all lines quiet for the latch setup time, then `XS_STROBE`.
- `XS_STROBE`: latch held low for the pulse width, then back to `XS_IDLE`, raising `done`.

Top module: `xps_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the outputs go to idle: `ser_clk`=0, `ser_data`=0, `latch_n`=1, `busy`=0, `done`=0.
- R2: A `start` sampled high while idle captures `map_in`, and `busy` is high from that edge on.
- R3: Bits are sent most significant first: bit k of the sending order (k=0..255) carries `map_in[255-k]`.
- R4: Count edges from the start edge E0. The serial clock rises at E0+HALF_DIV+2·HALF_DIV·k and falls at E0+2·HALF_DIV·(k+1). It stays high for HALF_DIV cycles per bit and idles low.
- R5: `ser_data` changes only on the edge where `ser_clk` falls (or at E0). It never changes on a rising edge.
- R6: `latch_n` goes low LATCH_GAP cycles after the final falling serial-clock edge. It stays low for exactly LATCH_LEN cycles, once per frame.
- R7: On the edge where `latch_n` returns high, `busy` drops and `done` is high for exactly one cycle.
- R8: A `start` while busy is ignored, and changes to `map_in` after capture have no effect on the frame.
- R9: Asserting reset in the middle of a frame returns the lines to idle, and a later frame runs normally.
- R10: `ser_data` is low whenever no bit is being sent: outside a frame and during the latch gap and pulse.
- R11: Each frame has exactly 256 rising serial-clock edges before the latch pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send a frame |
| map_in | input | MAP_W | Switch map, captured on an accepted start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the latch pulse ends |
| ser_clk | output | 1 | Serial clock to the switch |
| ser_data | output | 1 | Serial data to the switch |
| latch_n | output | 1 | Active-low latch strobe |

## Verification
The bench compares every output in every cycle of each frame against a cycle-indexed model.
- Map patterns of all zeros, all ones and a single set bit at either end would expose a reversed bit order or an off-by-one in the bit counter. Such a design would send 255 or 257 bits, or place the lone one in the wrong slot.
- A start pulse and a different map presented mid-frame catch a design that restarts or re-samples. The frame would come out corrupted.
- A reset mid-frame catches state that survives reset, which would leave the clock or latch stuck.
- The latch-gap and pulse-width cycles catch a latch that overlaps the last clock or is held too long.

// File: rtl/xps_pkg.sv
package xps_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_LEAD,
        XS_TRAIL,
        XS_GAP,
        XS_STROBE
    } xs_state_t;
endpackage

// File: rtl/xps_timer.sv
// Down-counter used to time each phase; expired marks the last cycle of a phase.
module xps_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/xps_map_shift.sv
// Holds the captured map and counts bits already sent.
module xps_map_shift #(
    parameter int MAP_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAP_W-1:0] map_in,
    input  logic             advance,
    output logic             next_msb,
    output logic             last_bit
);
    localparam int CNT_W = $clog2(MAP_W);

    logic [MAP_W-1:0] shreg;
    logic [CNT_W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (load) begin
            shreg <= map_in;
            bcnt  <= '0;
        end else if (advance) begin
            shreg <= {shreg[MAP_W-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
        end
    end

    // Bit that will sit at the head of the register after this edge.
    always_comb begin
        if (load)
            next_msb = map_in[MAP_W-1];
        else if (advance)
            next_msb = shreg[MAP_W-2];
        else
            next_msb = shreg[MAP_W-1];
    end

    assign last_bit = (bcnt == CNT_W'(MAP_W-1));
endmodule

// File: rtl/xps_loader.sv
module xps_loader
    import xps_pkg::*;
#(
    parameter int MAP_W     = 256,
    parameter int HALF_DIV  = 10,
    parameter int LATCH_GAP = 2,
    parameter int LATCH_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAP_W-1:0] map_in,
    output logic             busy,
    output logic             done,
    output logic             ser_clk,
    output logic             ser_data,
    output logic             latch_n
);
    localparam int MAX_PH = (HALF_DIV > LATCH_GAP)
                          ? ((HALF_DIV > LATCH_LEN) ? HALF_DIV : LATCH_LEN)
                          : ((LATCH_GAP > LATCH_LEN) ? LATCH_GAP : LATCH_LEN);
    localparam int TMR_W  = (MAX_PH < 2) ? 1 : $clog2(MAX_PH);

    xs_state_t        state, nxt;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             sh_load, sh_adv, next_msb, last_bit;

    xps_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    xps_map_shift #(.MAP_W(MAP_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .map_in   (map_in),
        .advance  (sh_adv),
        .next_msb (next_msb),
        .last_bit (last_bit)
    );

    // Next-state and phase control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        unique case (state)
            XS_IDLE: begin
                if (start) begin
                    nxt      = XS_LEAD;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HALF_DIV - 1);
                end
            end
            XS_LEAD: begin
                if (tmr_exp) begin
                    nxt      = XS_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HALF_DIV - 1);
                end
            end
            XS_TRAIL: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        nxt     = XS_GAP;
                        tmr_val = TMR_W'(LATCH_GAP - 1);
                    end else begin
                        nxt     = XS_LEAD;
                        sh_adv  = 1'b1;
                        tmr_val = TMR_W'(HALF_DIV - 1);
                    end
                end
            end
            XS_GAP: begin
                if (tmr_exp) begin
                    nxt      = XS_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(LATCH_LEN - 1);
                end
            end
            XS_STROBE: begin
                if (tmr_exp)
                    nxt = XS_IDLE;
            end
            default: nxt = XS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= XS_IDLE;
        else
            state <= nxt;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            latch_n  <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            ser_clk  <= (nxt == XS_TRAIL);
            ser_data <= (nxt == XS_LEAD || nxt == XS_TRAIL) ? next_msb : 1'b0;
            latch_n  <= (nxt != XS_STROBE);
            busy     <= (nxt != XS_IDLE);
            done     <= (state == XS_STROBE) && (nxt == XS_IDLE);
        end
    end
endmodule

// File: rtl/xps_loader_chk.sv
module xps_loader_chk #(
    parameter int MAP_W     = 256,
    parameter int LATCH_LEN = 2
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ser_clk,
    input logic ser_data,
    input logic latch_n
);
    localparam int RC_W = $clog2(MAP_W + 2);
    localparam int LL_W = $clog2(LATCH_LEN + 2);

    logic            clk_d;
    logic [RC_W-1:0] rise_cnt;
    logic [LL_W-1:0] low_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d    <= 1'b0;
            rise_cnt <= '0;
            low_len  <= '0;
        end else begin
            clk_d <= ser_clk;
            if (!busy)
                rise_cnt <= '0;
            else if (ser_clk && !clk_d)
                rise_cnt <= rise_cnt + 1'b1;
            if (latch_n)
                low_len <= '0;
            else
                low_len <= low_len + 1'b1;
        end
    end

    a_r5_data_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    a_r4_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && latch_n));

    a_r10_data_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || !latch_n) |-> !ser_data);

    a_r6_latch_quiet_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_n |-> (busy && !ser_clk));

    a_r6_latch_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_n |-> (low_len < LL_W'(LATCH_LEN)));

    a_r6_latch_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_n) |-> (low_len == LL_W'(LATCH_LEN)));

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && latch_n));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_n) |-> (rise_cnt == RC_W'(MAP_W)));
endmodule

bind xps_loader xps_loader_chk #(.MAP_W(MAP_W), .LATCH_LEN(LATCH_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .latch_n  (latch_n)
);

// File: tb/xps_loader_test.sv
module xps_loader_test;
    localparam int N  = 256;
    localparam int H  = 10;
    localparam int G  = 2;
    localparam int L  = 2;
    localparam int SER_END = 2 * H * N;
    localparam int FR_END  = SER_END + G + L;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] map_in = '0;
    logic         busy, done, ser_clk, ser_data, latch_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xps_loader #(.MAP_W(N), .HALF_DIV(H), .LATCH_GAP(G), .LATCH_LEN(L)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .map_in(map_in),
        .busy(busy), .done(done), .ser_clk(ser_clk), .ser_data(ser_data),
        .latch_n(latch_n)
    );

    // Expected {ser_clk, ser_data, latch_n, busy, done}, t cycles after the start edge
    function automatic logic [4:0] model(input int t, input logic [N-1:0] m);
        if (t < SER_END)
            return {((t % (2 * H)) >= H), m[N-1-(t / (2 * H))], 1'b1, 1'b1, 1'b0};
        else if (t < SER_END + G)
            return 5'b00110;
        else if (t < FR_END)
            return 5'b00010;
        else if (t == FR_END)
            return 5'b00101;
        return 5'b00100;
    endfunction

    function automatic string tag_of(input int t, input logic [4:0] d, input bit poke);
        if (poke)               return "R8";
        if (t == 0 && d[1])     return "R2";
        if (d[3] && t >= SER_END) return "R10";
        if (d[3])               return "R3";
        if (d[4])               return "R4";
        if (d[2])               return "R6";
        return "R7";
    endfunction

    task automatic check_vec(input string tag, input int t, input logic [4:0] exp_v);
        logic [4:0] got;
        got = {ser_clk, ser_data, latch_n, busy, done};
        n_chk++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0d clk/data/latch/busy/done got %b expected %b", tag, t, got, exp_v);
        end
    endtask

    task automatic run_frame(input logic [N-1:0] m, input bit poke);
        logic [4:0] e;
        @(negedge clk);
        map_in = m;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= FR_END + 1; t++) begin
            e = model(t, m);
            check_vec(tag_of(t, e ^ {ser_clk, ser_data, latch_n, busy, done}, poke), t, e);
            if (poke && t == 100) begin
                start  = 1'b1;
                map_in = ~m;
            end else if (poke && t == 101) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [N-1:0] rand_map();
        logic [N-1:0] m;
        for (int w = 0; w < N / 32; w++)
            m[w * 32 +: 32] = $urandom;
        return m;
    endfunction

    initial begin
        int seed_v;
        logic [N-1:0] am;
        seed_v = $urandom(32'h5eed_0a11);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check_vec("R1", -1, 5'b00100);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1", -1, 5'b00100);

        run_frame('0, 1'b0);
        run_frame('1, 1'b0);
        run_frame({1'b1, {(N-1){1'b0}}}, 1'b0);
        run_frame({{(N-1){1'b0}}, 1'b1}, 1'b0);
        for (int i = 0; i < N; i++) am[i] = i[0];
        run_frame(am, 1'b0);
        // R8: start and a new map offered mid-frame
        run_frame(rand_map(), 1'b1);
        for (int i = 0; i < 2; i++) run_frame(rand_map(), 1'b0);

        // R9: reset in the middle of a frame
        @(negedge clk);
        map_in = '1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3000) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R9", -1, 5'b00100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_vec("R9", -1, 5'b00100);
        run_frame(rand_map(), 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule